// File: doc/BRIEF.md
# Critical path test vector selector

This block keeps a small store of timing test entries for a circuit under test. Each entry holds two operand words, a launch word and a capture word, which are applied on consecutive cycles so that a path sees a rising or falling transition. It also holds the result the circuit should produce. The entries are loaded once through a plain write port, and the load address is the index. Index 0 is the entry for the slowest path, and the index grows as paths get less critical.

On a phase request the block issues a list of entry indices, one per cycle, and drives the stored operands and expected result of each one. It keeps a test order, which is a permutation of all indices. The head of each phase comes from the top of that order. The tail comes from a round-robin pointer that walks the rest of the order and keeps its place from one phase to the next, so every entry is tested now and then.

A fail report names an index. That index moves to the top of the order, so the next phase tests it first. With the default complexity of ten, a phase issues the eight top entries followed by two round-robin entries.

Top module: `crit_vec_selector`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` and `phase_done` are low. The order holds index i at position i. The round-robin pointer rests on position TOP_N.
- R2: A write with `ld_en` high stores `ld_opa`, `ld_opb` and `ld_exp` at index `ld_addr`. Every issued index appears on `out_idx` in the same cycle as the launch word (`out_opa`), the capture word (`out_opb`) and the expected result (`out_exp`) written for that index.
- R3: When `phase_start` is sampled high while idle, with a nonzero `phase_len`, a phase of length L begins. L is `phase_len`, or DEPTH if `phase_len` is larger. `out_valid` stays low on the edge that accepts the request. It is then high for exactly L consecutive cycles, starting one edge later.
- R4: The first min(L, TOP_N) items of a phase are order positions 0, 1, 2 and so on, issued in that sequence.
- R5: The remaining items come from the round-robin pointer. The pointer covers positions TOP_N to DEPTH-1, wraps from DEPTH-1 back to TOP_N, and advances by one for each item it supplies. Its value carries over to the next phase.
- R6: A fail report (`fail_valid` with `fail_idx`) puts that index at position 0 on the next edge. The entries that were above its old position each move down by one, and all others stay put. The order stays a permutation of all indices, so a full-depth phase issues every index exactly once.
- R7: `phase_done` is high for one cycle, together with the last issued item. `out_valid` is low in the cycle after `phase_done`.
- R8: While a phase is running, `phase_start` has no effect. A request with `phase_len` equal to 0 starts nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Store write strobe |
| ld_addr | input | AW | Index being written |
| ld_opa | input | OP_W | Launch operand to store |
| ld_opb | input | OP_W | Capture operand to store |
| ld_exp | input | RES_W | Expected result to store |
| phase_start | input | 1 | Phase request |
| phase_len | input | LW | Vectors per phase (complexity) |
| fail_valid | input | 1 | Fail report strobe |
| fail_idx | input | AW | Index of the failed entry |
| out_valid | output | 1 | Issued item valid |
| out_idx | output | AW | Index of the issued item |
| out_opa | output | OP_W | Launch operand of the issued item |
| out_opb | output | OP_W | Capture operand of the issued item |
| out_exp | output | RES_W | Expected result of the issued item |
| phase_done | output | 1 | Last item of the phase |

## Verification
The bench uses four kinds of phases, and each separates a different fault:
- A default phase of ten straight after reset separates head ordering from tail ordering.
- Repeated phases of ten, with a short phase of five between them, show that the round-robin pointer keeps its place and advances only for tail items.
- Full-depth phases, and one over-long request, show that the pointer wraps and that the order never duplicates or loses an index.
- Fail reports aimed at a tail entry, at a mid-head entry and at the entry already on top separate a correct shift-down from an overwrite or a swap.

Requests made in mid-phase and requests with zero length show that the phase control ignores what it should.

// File: rtl/vs_pkg.sv
package vs_pkg;
  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_mode_e;
endpackage

// File: rtl/vs_store.sv
module vs_store #(
  parameter int DEPTH = 64,
  parameter int OP_W  = 16,
  parameter int RES_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int W    = 2 * OP_W + RES_W
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  // Single write port and registered read port, suited to block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/vs_order.sv
module vs_order #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prom_valid,
  input  logic [AW-1:0]     prom_idx,
  input  logic [AW-1:0]     rd_pos,
  output logic [AW-1:0]     rd_idx,
  output logic [DEPTH*AW-1:0] ord_flat
);
  logic [AW-1:0]    ord_q [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [DEPTH-1:0] shift;

  // shift[i] is set when the promoted index sits at position i or below it.
  assign shift[DEPTH-1] = hit[DEPTH-1];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign hit[i] = (ord_q[i] == prom_idx);
    assign ord_flat[i*AW +: AW] = ord_q[i];

    if (i < DEPTH - 1) begin : g_chain
      assign shift[i] = hit[i] | shift[i+1];
    end

    if (i == 0) begin : g_top
      always_ff @(posedge clk) begin
        if (rst)             ord_q[0] <= '0;
        else if (prom_valid) ord_q[0] <= prom_idx;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (rst)                        ord_q[i] <= AW'(i);
        else if (prom_valid && shift[i]) ord_q[i] <= ord_q[i-1];
      end
    end
  end

  assign rd_idx = ord_q[rd_pos];
endmodule

// File: rtl/vs_sequencer.sv
module vs_sequencer
  import vs_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int TOP_N = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_start,
  input  logic [LW-1:0] phase_len,
  input  logic [AW-1:0] rd_idx,
  output logic          issue,
  output logic [AW-1:0] rd_pos,
  output logic          busy,
  output logic          out_valid,
  output logic [AW-1:0] out_idx,
  output logic          phase_done
);
  seq_mode_e     mode_q;
  logic [LW-1:0] cnt_q, len_q, head_q;
  logic [AW-1:0] rr_q;
  logic [LW-1:0] len_c, head_c;
  logic          in_tail, last;

  assign busy    = (mode_q == SEQ_RUN);
  assign issue   = busy;
  assign in_tail = (cnt_q >= head_q);
  assign last    = (cnt_q == len_q - LW'(1));
  assign rd_pos  = in_tail ? rr_q : AW'(cnt_q);

  always_comb begin
    len_c  = (phase_len > LW'(DEPTH)) ? LW'(DEPTH) : phase_len;
    head_c = (len_c > LW'(TOP_N)) ? LW'(TOP_N) : len_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q     <= SEQ_IDLE;
      cnt_q      <= '0;
      len_q      <= '0;
      head_q     <= '0;
      rr_q       <= AW'(TOP_N);
      out_valid  <= 1'b0;
      out_idx    <= '0;
      phase_done <= 1'b0;
    end else begin
      out_valid  <= issue;
      phase_done <= issue && last;
      if (issue) out_idx <= rd_idx;

      if (!busy) begin
        if (phase_start && (phase_len != '0)) begin
          mode_q <= SEQ_RUN;
          cnt_q  <= '0;
          len_q  <= len_c;
          head_q <= head_c;
        end
      end else begin
        cnt_q <= cnt_q + LW'(1);
        if (last) mode_q <= SEQ_IDLE;
        if (in_tail)
          rr_q <= (rr_q == AW'(DEPTH - 1)) ? AW'(TOP_N) : rr_q + AW'(1);
      end
    end
  end
endmodule

// File: rtl/crit_vec_selector.sv
module crit_vec_selector #(
  parameter int DEPTH = 64,
  parameter int TOP_N = 8,
  parameter int OP_W  = 16,
  parameter int RES_W = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [OP_W-1:0]  ld_opa,
  input  logic [OP_W-1:0]  ld_opb,
  input  logic [RES_W-1:0] ld_exp,
  input  logic             phase_start,
  input  logic [LW-1:0]    phase_len,
  input  logic             fail_valid,
  input  logic [AW-1:0]    fail_idx,
  output logic             out_valid,
  output logic [AW-1:0]    out_idx,
  output logic [OP_W-1:0]  out_opa,
  output logic [OP_W-1:0]  out_opb,
  output logic [RES_W-1:0] out_exp,
  output logic             phase_done
);
  localparam int W = 2 * OP_W + RES_W;

  logic              issue, busy;
  logic [AW-1:0]     rd_pos, rd_idx;
  logic [DEPTH*AW-1:0] ord_flat;
  logic [W-1:0]      rd_word;

  vs_order #(.DEPTH(DEPTH)) order_i (
    .clk        (clk),
    .rst        (rst),
    .prom_valid (fail_valid),
    .prom_idx   (fail_idx),
    .rd_pos     (rd_pos),
    .rd_idx     (rd_idx),
    .ord_flat   (ord_flat)
  );

  vs_sequencer #(.DEPTH(DEPTH), .TOP_N(TOP_N)) seq_i (
    .clk         (clk),
    .rst         (rst),
    .phase_start (phase_start),
    .phase_len   (phase_len),
    .rd_idx      (rd_idx),
    .issue       (issue),
    .rd_pos      (rd_pos),
    .busy        (busy),
    .out_valid   (out_valid),
    .out_idx     (out_idx),
    .phase_done  (phase_done)
  );

  vs_store #(.DEPTH(DEPTH), .OP_W(OP_W), .RES_W(RES_W)) store_i (
    .clk     (clk),
    .wr_en   (ld_en),
    .wr_addr (ld_addr),
    .wr_data ({ld_opa, ld_opb, ld_exp}),
    .rd_en   (issue),
    .rd_addr (rd_idx),
    .rd_data (rd_word)
  );

  assign out_opa = rd_word[W-1 -: OP_W];
  assign out_opb = rd_word[RES_W +: OP_W];
  assign out_exp = rd_word[RES_W-1:0];
endmodule

// File: rtl/crit_vec_selector_chk.sv
module crit_vec_selector_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input logic                clk,
  input logic                rst,
  input logic                fail_valid,
  input logic [AW-1:0]       fail_idx,
  input logic                busy,
  input logic                out_valid,
  input logic                phase_done,
  input logic [DEPTH*AW-1:0] ord_flat
);
  logic [DEPTH-1:0] seen;

  always_comb begin
    seen = '0;
    for (int i = 0; i < DEPTH; i++) seen[ord_flat[i*AW +: AW]] = 1'b1;
  end

  // R6: a reported index is on top one edge later
  a_r6_promote_head: assert property (@(posedge clk) disable iff (rst)
    fail_valid |=> (ord_flat[AW-1:0] == $past(fail_idx)));

  // R6: the order never loses or duplicates an index
  a_r6_permutation: assert property (@(posedge clk) disable iff (rst)
    (&seen));

  // R7: done only accompanies an issued item
  a_r7_done_with_valid: assert property (@(posedge clk) disable iff (rst)
    phase_done |-> out_valid);

  // R7: a quiet cycle follows the last item
  a_r7_gap_after_done: assert property (@(posedge clk) disable iff (rst)
    phase_done |=> !out_valid);

  // R3: nothing is issued without a running phase
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !out_valid);
endmodule

bind crit_vec_selector crit_vec_selector_chk #(.DEPTH(DEPTH), .AW(AW)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .fail_valid (fail_valid),
  .fail_idx   (fail_idx),
  .busy       (busy),
  .out_valid  (out_valid),
  .phase_done (phase_done),
  .ord_flat   (ord_flat)
);

// File: tb/crit_vec_selector_tb_top.sv
`timescale 1ns/1ps
module crit_vec_selector_tb_top;
  localparam int DEPTH = 64;
  localparam int TOP_N = 8;
  localparam int AW    = 6;
  localparam int LW    = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ld_en = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [15:0] ld_opa = '0, ld_opb = '0, ld_exp = '0;
  logic phase_start = 1'b0;
  logic [LW-1:0] phase_len = '0;
  logic fail_valid = 1'b0;
  logic [AW-1:0] fail_idx = '0;
  logic out_valid, phase_done;
  logic [AW-1:0] out_idx;
  logic [15:0] out_opa, out_opb, out_exp;

  int checks = 0;
  int errors = 0;
  int ord_m [DEPTH];
  int rr_m;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  crit_vec_selector dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_opa(ld_opa), .ld_opb(ld_opb), .ld_exp(ld_exp),
    .phase_start(phase_start), .phase_len(phase_len),
    .fail_valid(fail_valid), .fail_idx(fail_idx),
    .out_valid(out_valid), .out_idx(out_idx), .out_opa(out_opa),
    .out_opb(out_opb), .out_exp(out_exp), .phase_done(phase_done)
  );

  function automatic logic [15:0] opa_of(int i); return 16'(i * 3 + 1); endfunction
  function automatic logic [15:0] opb_of(int i); return 16'(i ^ 'h5A); endfunction
  function automatic logic [15:0] exp_of(int i); return 16'(i * 7 + 2); endfunction

  task automatic chk(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic model_promote(int v);
    int p = 0;
    for (int j = 0; j < DEPTH; j++) if (ord_m[j] == v) p = j;
    for (int j = p; j > 0; j--) ord_m[j] = ord_m[j-1];
    ord_m[0] = v;
  endtask

  task automatic send_fail(int v);
    @(negedge clk);
    fail_valid = 1'b1; fail_idx = AW'(v);
    @(negedge clk);
    fail_valid = 1'b0;
    model_promote(v);
  endtask

  // Runs one phase and checks every issued item against the model.
  task automatic run_phase(int len, string req, bit poke, bit full_cover);
    int eff  = (len > DEPTH) ? DEPTH : len;
    int head = (eff > TOP_N) ? TOP_N : eff;
    bit [DEPTH-1:0] seen = '0;
    @(negedge clk);
    phase_start = 1'b1; phase_len = LW'(len);
    @(negedge clk);
    phase_start = 1'b0;
    chk(out_valid == 1'b0, "R3", "valid on accept edge", int'(out_valid), 0);
    for (int k = 0; k < eff; k++) begin
      int ei;
      if (k < head) ei = ord_m[k];
      else begin
        ei = ord_m[rr_m];
        rr_m = (rr_m == DEPTH - 1) ? TOP_N : rr_m + 1;
      end
      @(negedge clk);
      chk(out_valid == 1'b1, "R3", "valid in phase", int'(out_valid), 1);
      chk(int'(out_idx) == ei, (k < head) ? "R4" : "R5", "index", int'(out_idx), ei);
      chk(out_opa == opa_of(ei) && out_opb == opb_of(ei) && out_exp == exp_of(ei),
          "R2", "stored data", int'(out_exp), int'(exp_of(ei)));
      chk(phase_done == (k == eff - 1), "R7", "done position", int'(phase_done), int'(k == eff - 1));
      seen[out_idx] = 1'b1;
      if (poke && k == 2) phase_start = 1'b1;
      if (poke && k == 3) phase_start = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R7", "valid after done", int'(out_valid), 0);
    if (full_cover)
      chk($countones(seen) == DEPTH, "R6", "distinct indices in full phase", $countones(seen), DEPTH);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && phase_done == 1'b0, "R1", "outputs in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && phase_done == 1'b0, "R1", "outputs after reset", int'(out_valid), 0);
    for (int i = 0; i < DEPTH; i++) ord_m[i] = i;
    rr_m = TOP_N;
  endtask

  task automatic t_load();
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = AW'(i);
      ld_opa = opa_of(i); ld_opb = opb_of(i); ld_exp = exp_of(i);
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  // R1, R4, R5: identity order and pointer start give 0..7 then 8, 9
  task automatic t_default_phase();
    run_phase(10, "R1", 1'b0, 1'b0);
  endtask

  // R5: pointer persists; a short phase has no tail and leaves it alone
  task automatic t_rotation();
    run_phase(10, "R5", 1'b0, 1'b0);
    run_phase(5, "R4", 1'b0, 1'b0);
    run_phase(10, "R5", 1'b0, 1'b0);
  endtask

  // R6: promotion from the tail, from mid-head, and of the top entry
  task automatic t_promote();
    send_fail(40);
    run_phase(10, "R6", 1'b0, 1'b0);
    send_fail(3);
    run_phase(10, "R6", 1'b0, 1'b0);
    send_fail(3);
    send_fail(63);
    run_phase(10, "R6", 1'b0, 1'b0);
  endtask

  // R5, R6: full-depth and over-long phases wrap the pointer
  task automatic t_wrap();
    run_phase(DEPTH, "R5", 1'b0, 1'b1);
    run_phase(70, "R3", 1'b0, 1'b1);
  endtask

  // R8: a request during a phase is ignored
  task automatic t_busy_start();
    run_phase(10, "R8", 1'b1, 1'b0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "no phase from mid-phase request", int'(out_valid), 0);
    end
  endtask

  // R8: zero length starts nothing
  task automatic t_zero_len();
    @(negedge clk);
    phase_start = 1'b1; phase_len = '0;
    @(negedge clk);
    phase_start = 1'b0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8", "zero-length request", int'(out_valid), 0);
    end
    run_phase(10, "R8", 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_load();
    t_default_phase();
    t_rotation();
    t_promote();
    t_wrap();
    t_busy_start();
    t_zero_len();
    done_flag = 1'b1;
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
    end
  end
endmodule